// File: doc/BRIEF.md
# Rippling Magnitude Comparator

This block compares two equal-width operands and reports whether the first is smaller than, equal to, or larger than the second. It is a chain of identical one-bit stages. The stage for bit 0 starts from a fixed "equal" verdict. Each stage passes a two-bit verdict code to the stage above it, and the last stage's code is the block's answer. When the two bits of a stage differ, that stage overrides whatever it receives. When they match, the stage forwards the verdict from below without change. The highest differing bit therefore decides.

A mode input chooses between an unsigned and a two's-complement reading of the operands. For the signed reading, only the topmost stage changes: its two operand bits are exchanged. A set sign bit then counts as "smaller" rather than "larger". When both sign bits match, the answer comes from the lower bits, and this stays correct for two negative operands. The block is purely combinational. The code is decoded into three one-hot flags for use by downstream logic.

Top module: `mag_cmp_chain`

## Requirements
- R1: The verdict code is 2'b00 for equal, 2'b01 for first operand smaller and 2'b10 for first operand larger; 2'b11 never appears on `verdict` or on any link between stages.
- R2: A stage whose operand bits are a=1, b=0 emits 2'b10 and a stage with a=0, b=1 emits 2'b01, whatever code it receives.
- R3: A stage whose operand bits are equal emits exactly the code it receives.
- R4: The bit-0 stage is seeded with 2'b00, so identical operands give verdict 2'b00 in either mode.
- R5: With `signed_mode`=0 the verdict matches an unsigned comparison of `opa` and `opb`.
- R6: With `signed_mode`=1 and sign bits opa=0, opb=1 the verdict is 2'b10, and with opa=1, opb=0 it is 2'b01, whatever the lower bits are.
- R7: With `signed_mode`=1 and equal sign bits, both clear or both set, the verdict matches a two's-complement comparison.
- R8: Exactly one of `is_lt`, `is_eq` and `is_gt` is high: `is_lt` for code 2'b01, `is_eq` for 2'b00 and `is_gt` for 2'b10.
- R9: The highest differing bit decides the verdict even when every lower bit points the other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| signed_mode | input | 1 | 1 = two's-complement reading, 0 = unsigned |
| verdict | output | 2 | Final verdict code |
| is_lt | output | 1 | First operand smaller |
| is_eq | output | 1 | Operands equal |
| is_gt | output | 1 | First operand larger |

## Verification
Two decisions can apply in the same evaluation. One is the sign-stage override in signed mode. The other is the verdict rippling up from the lower bits. The test provokes this with operand pairs whose sign bits differ while the remaining bits point the opposite way, for example 0x8000 against 0x7FFF, and with pairs of negative operands whose sign bits match. Each result is judged against a two's-complement reference computed in the bench. The same pairs are also run in unsigned mode, where the verdict must flip.

// File: rtl/mag_cmp_pkg.sv
// Package: shared verdict encoding for the rippling comparator.
// Assumes: 2'b11 is never produced by any stage.
package mag_cmp_pkg;
    typedef enum logic [1:0] {
        VERD_EQ = 2'b00,
        VERD_LT = 2'b01,
        VERD_GT = 2'b10
    } verdict_e;
endpackage

// File: rtl/mag_cmp_stage.sv
// Module: one comparator stage. Overrides the incoming verdict when its bits
// differ, and forwards it when they match.
// Assumes: the incoming code is never 2'b11; its output is then don't-care.
module mag_cmp_stage #(
    parameter bit SHARE_TERMS = 1'b1
) (
    input  logic       bit_a,
    input  logic       bit_b,
    input  logic [1:0] code_in,
    output logic [1:0] code_out
);
    logic a_hi;   // this bit says a > b
    logic b_hi;   // this bit says a < b

    // Purpose: detect a local difference in each direction
    always_comb begin
        a_hi = bit_a & ~bit_b;
        b_hi = ~bit_a & bit_b;
    end

    generate
        if (SHARE_TERMS) begin : g_shared
            // Purpose: reuse each direction term's complement as the pass enable of the other
            always_comb begin
                code_out[1] = a_hi | (~b_hi & code_in[1]);
                code_out[0] = b_hi | (~a_hi & code_in[0]);
            end
        end else begin : g_plain
            // Purpose: sum-of-products form straight from the truth table
            always_comb begin
                code_out[1] = a_hi | (bit_a & code_in[1]) | (~bit_b & code_in[1]);
                code_out[0] = b_hi | (~bit_a & code_in[0]) | (bit_b & code_in[0]);
            end
        end
    endgenerate

    // Purpose: guard the stage's contract
    always_comb begin
        if (!$isunknown({bit_a, bit_b, code_in}) && code_in != 2'b11) begin
            a_r1_stage_no_illegal: assert (code_out != 2'b11)
                else $error("stage produced illegal code");
            if (bit_a == bit_b) begin
                a_r3_pass_through: assert (code_out == code_in)
                    else $error("stage did not forward code");
            end else begin
                a_r2_local_override: assert (code_out == {bit_a, bit_b})
                    else $error("stage did not override code");
            end
        end
    end
endmodule

// File: rtl/mag_cmp_decode.sv
// Module: turns the final verdict code into three one-hot flags.
// Assumes: the code is one of the three legal values.
module mag_cmp_decode
    import mag_cmp_pkg::*;
(
    input  logic [1:0] code,
    output logic       flag_lt,
    output logic       flag_eq,
    output logic       flag_gt
);
    // Purpose: one flag per legal code value
    always_comb begin
        flag_lt = (code == VERD_LT);
        flag_eq = (code == VERD_EQ);
        flag_gt = (code == VERD_GT);
    end

    // Purpose: the flags must be one-hot whenever the code is defined
    always_comb begin
        if (!$isunknown(code)) begin
            a_r8_onehot_flags: assert ($countones({flag_lt, flag_eq, flag_gt}) == 1)
                else $error("flags not one-hot");
        end
    end
endmodule

// File: rtl/mag_cmp_chain.sv
// Module: top of the rippling comparator. Chains WIDTH stages from the LSB
// upward and swaps the sign-stage inputs in signed mode.
// Assumes: WIDTH >= 2; purely combinational, no clock or reset.
module mag_cmp_chain
    import mag_cmp_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter bit SHARE_TERMS = 1'b1
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             signed_mode,
    output logic [1:0]       verdict,
    output logic             is_lt,
    output logic             is_eq,
    output logic             is_gt
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0][1:0] link;   // link[i] feeds stage i; link[WIDTH] is the result

    assign link[0] = VERD_EQ;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_stage
            logic sa;
            logic sb;
            if (i == MSB) begin : g_sign
                // Purpose: exchange the sign bits when reading as two's complement
                always_comb begin
                    sa = signed_mode ? opb[i] : opa[i];
                    sb = signed_mode ? opa[i] : opb[i];
                end
            end else begin : g_mag
                // Purpose: magnitude bits go straight through
                always_comb begin
                    sa = opa[i];
                    sb = opb[i];
                end
            end
            mag_cmp_stage #(.SHARE_TERMS(SHARE_TERMS)) u_stage (
                .bit_a   (sa),
                .bit_b   (sb),
                .code_in (link[i]),
                .code_out(link[i+1])
            );
        end
    endgenerate

    assign verdict = link[WIDTH];

    mag_cmp_decode u_decode (
        .code   (verdict),
        .flag_lt(is_lt),
        .flag_eq(is_eq),
        .flag_gt(is_gt)
    );

    // Purpose: relate the chain's result to the operands directly
    always_comb begin
        if (!$isunknown({opa, opb, signed_mode})) begin
            a_r4_equal_operands: assert (is_eq == (opa == opb))
                else $error("equality verdict wrong");
            if (signed_mode && opa[MSB] != opb[MSB]) begin
                a_r6_sign_decides: assert (verdict == {opb[MSB], opa[MSB]})
                    else $error("sign stage did not decide");
            end
            if (!signed_mode) begin
                a_r5_unsigned_lt: assert (is_lt == (opa < opb))
                    else $error("unsigned verdict wrong");
            end
        end
    end
endmodule

// File: tb/mag_cmp_chain_tb.sv
module mag_cmp_chain_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;

    logic [15:0] a16, b16;
    logic        m16;
    logic [1:0]  v16;
    logic        lt16, eq16, gt16;
    logic [3:0]  a4, b4;
    logic        m4;
    logic [1:0]  v4;
    logic        lt4, eq4, gt4;

    mag_cmp_chain #(.WIDTH(16)) u_dut (
        .opa(a16), .opb(b16), .signed_mode(m16),
        .verdict(v16), .is_lt(lt16), .is_eq(eq16), .is_gt(gt16)
    );
    mag_cmp_chain #(.WIDTH(4), .SHARE_TERMS(1'b0)) u_dut4 (
        .opa(a4), .opb(b4), .signed_mode(m4),
        .verdict(v4), .is_lt(lt4), .is_eq(eq4), .is_gt(gt4)
    );

    function automatic logic [1:0] ref16(logic [15:0] a, logic [15:0] b, logic s);
        if (a == b) return 2'b00;
        if (s) return ($signed(a) < $signed(b)) ? 2'b01 : 2'b10;
        return (a < b) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] ref4(logic [3:0] a, logic [3:0] b, logic s);
        if (a == b) return 2'b00;
        if (s) return ($signed(a) < $signed(b)) ? 2'b01 : 2'b10;
        return (a < b) ? 2'b01 : 2'b10;
    endfunction

    task automatic judge(string tag, logic [1:0] got, logic l, logic e, logic g, logic [1:0] exp);
        logic [2:0] fexp;
        fexp = {exp == 2'b01, exp == 2'b00, exp == 2'b10};
        checks++;
        if (got !== exp || {l, e, g} !== fexp) begin
            errors++;
            $display("FAIL %s verdict=%b flags=%b expected verdict=%b flags=%b",
                     tag, got, {l, e, g}, exp, fexp);
        end
    endtask

    task automatic run16(string tag, logic [15:0] a, logic [15:0] b, logic s, logic [1:0] exp);
        @(posedge clk);
        a16 = a; b16 = b; m16 = s;
        @(negedge clk);
        judge(tag, v16, lt16, eq16, gt16, exp);
    endtask

    // R4: zero operands after reset give the equal verdict
    task automatic t_reset_state();
        run16("R4 zero operands unsigned", 16'h0, 16'h0, 1'b0, 2'b00);
        run16("R4 zero operands signed", 16'h0, 16'h0, 1'b1, 2'b00);
        run16("R4 equal negative", 16'hBEEF, 16'hBEEF, 1'b1, 2'b00);
    endtask

    // R1 R5 R7 R8: all 4-bit pairs in both modes against the reference
    task automatic t_exhaustive4();
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    a4 = a[3:0]; b4 = b[3:0]; m4 = s[0];
                    @(negedge clk);
                    judge(s ? "R7 4-bit signed" : "R5 4-bit unsigned",
                          v4, lt4, eq4, gt4, ref4(a[3:0], b[3:0], s[0]));
                end
    endtask

    // R2 R3: a single differing bit at each position decides; equal bits forward
    task automatic t_single_bit();
        for (int i = 0; i < 15; i++) begin
            run16("R2 a bit set", 16'h1 << i, 16'h0, 1'b0, 2'b10);
            run16("R2 b bit set", 16'h0, 16'h1 << i, 1'b0, 2'b01);
            run16("R3 upper equal bits forward", (16'h1 << i) | 16'h8000, 16'h8000, 1'b1, 2'b10);
        end
    endtask

    // R6 R9: sign stage and lower bits disagree
    task automatic t_sign_conflict();
        run16("R6 neg vs pos", 16'h8000, 16'h7FFF, 1'b1, 2'b01);
        run16("R6 pos vs neg", 16'h7FFF, 16'h8000, 1'b1, 2'b10);
        run16("R9 msb decides unsigned", 16'h8000, 16'h7FFF, 1'b0, 2'b10);
        run16("R9 msb decides unsigned rev", 16'h7FFF, 16'h8000, 1'b0, 2'b01);
        run16("R6 zero vs minus one", 16'h0000, 16'hFFFF, 1'b1, 2'b10);
        run16("R7 both negative", 16'hFFFE, 16'hFFFF, 1'b1, 2'b01);
        run16("R7 both negative rev", 16'h8001, 16'h8000, 1'b1, 2'b10);
        run16("R9 bit 14 over lower", 16'h4000, 16'h3FFF, 1'b1, 2'b10);
    endtask

    // R5 R7: random 16-bit pairs in both modes
    task automatic t_random16();
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] a, b;
            logic s;
            a = 16'($urandom);
            b = (n % 8 == 0) ? a ^ (16'h1 << (n % 16)) : 16'($urandom);
            s = n[0];
            run16(s ? "R7 random signed" : "R5 random unsigned", a, b, s, ref16(a, b, s));
        end
    endtask

    initial begin
        a16 = '0; b16 = '0; m16 = 1'b0;
        a4 = '0; b4 = '0; m4 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_exhaustive4();
        t_single_bit();
        t_sign_conflict();
        t_random16();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule